// File: doc/BRIEF.md
# Memory-Operand Add/Subtract Sequencer Core

This block is a very small processor whose whole instruction set is two three-address operations, add and subtract, plus a stop code. There is no register file and no way to form a constant. Each arithmetic instruction names two source addresses and one destination address in data memory, and the core writes the wrapped sum or difference of the two source words to the destination.

Instructions run strictly one after another. Each instruction passes through five one-cycle phases: fetch/decode, read first operand, read second operand, compute, and write result. No two instructions overlap, so the core retires one instruction every five cycles. The data memory has a single port with one cycle of read latency. The core makes at most one data access per cycle, and each read value is taken in the phase after its address was presented. Instruction memory is read combinationally at the program counter. A stop code parks the core and raises `halted` until the next reset.

Top module: `memcalc_core`

## Requirements
- R1: Opcode 00 writes (mem[a] + mem[b]) mod 2^16 to address c.
- R2: Opcode 01 writes (mem[a] - mem[b]) mod 2^16 to address c.
- R3: The instruction word is 26 bits. The opcode is in bits 25:24, source a in bits 23:16, source b in bits 15:8 and destination c in bits 7:0.
- R4: Every arithmetic instruction takes exactly five cycles. The next fetch comes five cycles after the previous one, so N instructions followed by a stop code raise `halted` 5N+1 cycles after reset is released.
- R5: Within an instruction the data port is used in a fixed order. In cycle 2 it shows address a with no write. In cycle 3 it shows address b with no write. In cycle 4 there is no write. In cycle 5 it shows address c with the write enable high and the result on the write data. That is a single write for each instruction.
- R6: The program counter (`imem_addr`) is 0 out of reset and increases by one after each result write.
- R7: An opcode with bit 25 set (10 or 11) is a stop code. Once it is fetched, `halted` rises and stays high until reset, no data write occurs, and the program counter does not move.
- R8: Synchronous reset, including one applied in the middle of an instruction, returns the core to the fetch phase. After it, `imem_addr` is 0 and `halted` and `dmem_we` are low.
- R9: A destination may equal a source. A result written by one instruction is seen as an operand by the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 8 | Program counter, instruction fetch address |
| imem_data | input | 26 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 8 | Data memory address |
| dmem_rdata | input | 16 | Data read, one cycle after its address |
| dmem_wdata | output | 16 | Data to write |
| dmem_we | output | 1 | Data write enable |
| halted | output | 1 | Core stopped on a stop code |

## Verification
The bench goes after carries and borrows that wrap past 16 bits. A core with a wider adder or a swapped operand order would write a wrong low word or a negated difference. Aliased addresses, where a equals b or c equals a source, catch a core that reads the second operand too early or from a stale capture. Such a core would use the first word twice, or last instruction's value. The exact cycle of each address and of the single write is checked, along with the 5N+1 cycle count to `halted`. This exposes an off-by-one phase, a missing wait for read latency, or a counter that advances at the wrong time. Both stop codes, and a reset in the middle of an instruction, are used to catch a core that writes after stopping or resumes from a stale phase.

// File: rtl/memcalc_core.sv
module memcalc_core #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int PC_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [PC_W-1:0]       imem_addr,
  input  logic [3*ADDR_W+1:0]   imem_data,
  output logic [ADDR_W-1:0]     dmem_addr,
  input  logic [DATA_W-1:0]     dmem_rdata,
  output logic [DATA_W-1:0]     dmem_wdata,
  output logic                  dmem_we,
  output logic                  halted
);
  localparam int INSTR_W = 3*ADDR_W + 2;

  typedef enum logic [2:0] {
    PH_FETCH, PH_RDA, PH_RDB, PH_EXEC, PH_WRC, PH_HALT
  } phase_t;

  phase_t              ph;
  logic [PC_W-1:0]     pc;
  logic [INSTR_W-1:0]  ir;
  logic [DATA_W-1:0]   opa, res;
  logic [ADDR_W-1:0]   fa, fb, fc;
  logic                is_sub;

  assign fa     = ir[3*ADDR_W-1:2*ADDR_W];
  assign fb     = ir[2*ADDR_W-1:ADDR_W];
  assign fc     = ir[ADDR_W-1:0];
  assign is_sub = ir[INSTR_W-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_FETCH;
      pc  <= '0;
      ir  <= '0;
      opa <= '0;
      res <= '0;
    end else begin
      case (ph)
        PH_FETCH: begin
          ir <= imem_data;
          ph <= imem_data[INSTR_W-1] ? PH_HALT : PH_RDA;
        end
        PH_RDA:  ph <= PH_RDB;
        PH_RDB: begin
          opa <= dmem_rdata;
          ph  <= PH_EXEC;
        end
        PH_EXEC: begin
          res <= is_sub ? opa - dmem_rdata : opa + dmem_rdata;
          ph  <= PH_WRC;
        end
        PH_WRC: begin
          pc <= pc + 1'b1;
          ph <= PH_FETCH;
        end
        default: ph <= PH_HALT;
      endcase
    end
  end

  always_comb begin
    case (ph)
      PH_RDA:  dmem_addr = fa;
      PH_RDB:  dmem_addr = fb;
      PH_WRC:  dmem_addr = fc;
      default: dmem_addr = '0;
    endcase
  end

  assign dmem_we    = (ph == PH_WRC);
  assign dmem_wdata = res;
  assign halted     = (ph == PH_HALT);
  assign imem_addr  = pc;

  a_r5_single_write: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> !dmem_we);

  a_r4_five_phase: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (!$past(dmem_we) && !$past(dmem_we,2) && !$past(dmem_we,3) && !$past(halted,4)));

  a_r6_pc_advance: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> imem_addr == PC_W'($past(imem_addr) + 1'b1));

  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !dmem_we && $stable(imem_addr)));

  a_r3_read_a_addr: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_FETCH && !imem_data[INSTR_W-1]) |=>
      dmem_addr == $past(imem_data[3*ADDR_W-1:2*ADDR_W]));

  a_r8_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (imem_addr == '0 && !halted && !dmem_we));
endmodule

// File: tb/tb_memcalc_core.sv
module tb_memcalc_core;
  localparam int PERIOD = 10;
  localparam int NVEC = 8;
  localparam logic [25:0] STOP = 26'h3000000;
  // {op, a, b, c, value at a, value at b}
  localparam logic [57:0] VEC [NVEC] = '{
    {2'b00, 8'd1,  8'd2,   8'd3,   16'd5,     16'd7},
    {2'b00, 8'd4,  8'd5,   8'd6,   16'hFFFF,  16'd2},
    {2'b01, 8'd7,  8'd8,   8'd9,   16'h0010,  16'h0004},
    {2'b01, 8'd11, 8'd12,  8'd13,  16'd3,     16'd5},
    {2'b00, 8'd10, 8'd10,  8'd14,  16'h4000,  16'h4000},
    {2'b01, 8'd20, 8'd21,  8'd20,  16'd100,   16'd1},
    {2'b00, 8'd0,  8'd255, 8'd255, 16'd1,     16'h7FFF},
    {2'b01, 8'd30, 8'd30,  8'd31,  16'h1234,  16'h1234}
  };

  logic clk = 0, rst = 1;
  logic [7:0] imem_addr, dmem_addr;
  logic [25:0] imem_data;
  logic [15:0] dmem_rdata, dmem_wdata;
  logic dmem_we, halted;
  logic [25:0] imem [256];
  logic [15:0] mem [256];
  logic ld_en = 0;
  logic [7:0] ld_addr = 0;
  logic [15:0] ld_data = 0;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  memcalc_core dut (.clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .halted(halted));

  assign imem_data = imem[imem_addr];

  always @(posedge clk) begin
    dmem_rdata <= mem[dmem_addr];
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (dmem_we) mem[dmem_addr] <= dmem_wdata;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); ld_en = 1; ld_addr = a; ld_data = d;
    @(posedge clk); #1; ld_en = 0;
  endtask

  task automatic release_rst();
    @(negedge clk); rst = 0; #1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD*100000);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    logic [15:0] ev;
    logic [7:0] va_a, vb_a, vc_a;
    logic [1:0] op;
    int wcnt;
    for (int i = 0; i < 256; i++) imem[i] = STOP;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (2) step();
    chk(imem_addr == 0 && !halted && !dmem_we, "R8 reset state", {imem_addr, 7'b0, halted, dmem_we}, 0);

    for (int v = 0; v < NVEC; v++) begin
      {op, va_a, vb_a, vc_a} = VEC[v][57:32];
      rst = 1;
      load(va_a, VEC[v][31:16]);
      load(vb_a, VEC[v][15:0]);
      ev = op[0] ? mem[va_a] - mem[vb_a] : mem[va_a] + mem[vb_a];
      imem[0] = VEC[v][57:32];
      imem[1] = STOP;
      release_rst();
      chk(imem_addr == 0 && !dmem_we, "R6 pc zero", imem_addr, 0);
      step();
      chk(dmem_addr == va_a && !dmem_we, "R3 R5 read a", dmem_addr, va_a);
      step();
      chk(dmem_addr == vb_a && !dmem_we, "R3 R5 read b", dmem_addr, vb_a);
      step();
      chk(!dmem_we, "R5 compute no write", dmem_we, 0);
      step();
      chk(dmem_we && dmem_addr == vc_a, "R5 write c", dmem_addr, vc_a);
      chk(dmem_wdata == ev, op[0] ? "R2 sub result" : "R1 add result", dmem_wdata, ev);
      step();
      chk(imem_addr == 1 && !halted && !dmem_we, "R4 R6 next fetch", imem_addr, 1);
      step();
      chk(halted, "R4 R7 halt after 6", halted, 1);
      chk(mem[vc_a] == ev, "R1 R2 R9 memory", mem[vc_a], ev);
    end

    // R9 chained program
    rst = 1;
    load(8'd1, 16'd3);
    load(8'd2, 16'd4);
    imem[0] = {2'b00, 8'd1, 8'd2, 8'd3};
    imem[1] = {2'b01, 8'd3, 8'd1, 8'd4};
    imem[2] = {2'b00, 8'd4, 8'd3, 8'd3};
    imem[3] = STOP;
    release_rst();
    repeat (15) step();
    chk(!halted, "R4 not halted at 15", halted, 0);
    step();
    chk(halted && imem_addr == 3, "R4 R6 halted at 16", imem_addr, 3);
    chk(mem[3] == 16'd11, "R9 chain result", mem[3], 11);
    chk(mem[4] == 16'd4, "R9 chain middle", mem[4], 4);
    wcnt = 0;
    for (int k = 0; k < 10; k++) begin
      step();
      if (dmem_we || !halted || imem_addr != 3) wcnt++;
    end
    chk(wcnt == 0, "R7 halt sticky quiet", wcnt, 0);

    // R7 opcode 10 stops
    rst = 1;
    load(8'd40, 16'h55AA);
    load(8'd41, 16'h0001);
    imem[0] = {2'b10, 8'd40, 8'd41, 8'd40};
    release_rst();
    step();
    chk(halted && imem_addr == 0, "R7 opcode 10 halts", halted, 1);
    repeat (6) step();
    chk(mem[40] == 16'h55AA, "R7 no write on stop", mem[40], 16'h55AA);

    // R8 reset mid-instruction
    rst = 1;
    load(8'd50, 16'd9);
    load(8'd51, 16'd6);
    imem[0] = {2'b01, 8'd50, 8'd51, 8'd52};
    imem[1] = STOP;
    release_rst();
    repeat (3) step();
    @(negedge clk); rst = 1;
    step();
    chk(imem_addr == 0 && !halted && !dmem_we, "R8 mid reset", imem_addr, 0);
    release_rst();
    repeat (6) step();
    chk(halted && mem[52] == 16'd3, "R8 R2 rerun after reset", mem[52], 3);

    summary();
  end
endmodule